// File: doc/BRIEF.md
# Slow Colour-Cycling Pattern Source

This block feeds a video controller's 8-bit pixel data input with one colour code that fills the whole visible area, and steps that code through all 256 values over time. The controller paints the code on every pixel, so the screen shows one flat colour that changes every so often. Sync timing, the controller and any frame store lie outside the block.

Everything runs on the single 14 MHz pixel-domain clock. A chain of three cascaded prescaler stages produces a one-cycle count enable. The stages divide by 256, then 256, then 128. With this enable an 8-bit binary up counter advances by one, which gives a colour change about every 0.6 s. The width of each stage is a parameter, so a test build can shorten the chain and see many wraps in a short run.

Top module: `colour_cycle_gen`

## Requirements
- R1: The reset rst_ni is active low and synchronous. On a rising edge with rst_ni low, colour_o becomes 0 and every prescaler stage clears. Driving rst_ni low between edges does not change colour_o before the next rising edge.
- R2: colour_o is an 8-bit plain binary code. It rises by exactly one on each prescaler enable pulse and changes only on rising clock edges.
- R3: After code 255, the next enable pulse returns colour_o to 0, and the sequence 0,1,...,255 repeats.
- R4: The enable pulse comes once every 2^(STAGE0_BITS+STAGE1_BITS+STAGE2_BITS) clocks. The defaults are 8, 8 and 7 bits, which gives one pulse per 8,388,608 clocks, about 1.67 colour changes per second at 14 MHz.
- R5: After reset is released, colour_o holds 0 for exactly 2^(sum of stage bits) rising edges and becomes 1 on that edge. Between two enable pulses colour_o holds its value.
- R6: Each prescaler stage advances only while the stage before it is at its terminal count (the first stage advances every clock). A stage wraps from all ones to zero. No derived clocks are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 14 MHz pixel-domain clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| colour_o | output | 8 | Colour code for the video controller's pixel data input |

## Verification
A wrong prescaler count or terminal-count decode shows up at colour_o as a step that comes early or late. In the shortened test build such an error appears within the first 2^(sum of stage bits) edges after reset. A fault in the colour register shows as a skipped or repeated code, or a missed wrap, at the next enable pulse after it occurs. The sweep therefore checks every code across two full wraps, and the reset checks confirm that nothing moves between edges.

// File: rtl/colour_cycle_pkg.sv
package colour_cycle_pkg;
  localparam int unsigned COLOUR_W   = 8;
  localparam int unsigned NUM_STAGES = 3;
  typedef logic [COLOUR_W-1:0] colour_t;
endpackage

// File: rtl/prescale_stage.sv
module prescale_stage #(
  parameter int unsigned W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  // terminal count passed on to the next stage
  assign tick_o = en_i && (cnt_q == MAX);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt_q == MAX) |=> cnt_q == '0);
  assert_clear_R1: assert property (@(posedge clk_i)
    !rst_ni |=> cnt_q == '0);
endmodule

// File: rtl/prescale_chain.sv
module prescale_chain
  import colour_cycle_pkg::*;
#(
  parameter int unsigned STAGE0_BITS = 8,
  parameter int unsigned STAGE1_BITS = 8,
  parameter int unsigned STAGE2_BITS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  logic [NUM_STAGES:0] en;
  assign en[0] = 1'b1;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    localparam int unsigned SW = (i == 0) ? STAGE0_BITS :
                                 (i == 1) ? STAGE1_BITS : STAGE2_BITS;
    prescale_stage #(.W(SW)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[i]),
      .tick_o (en[i+1])
    );
  end

  assign step_o = en[NUM_STAGES];
endmodule

// File: rtl/colour_counter.sv
module colour_counter
  import colour_cycle_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    step_i,
  output colour_t colour_o
);
  colour_t colour_q;

  // natural 8-bit overflow provides the 255 -> 0 wrap
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     colour_q <= '0;
    else if (step_i) colour_q <= colour_q + 1'b1;
  end

  assign colour_o = colour_q;

  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(colour_q));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && colour_q != '1) |=> colour_q == $past(colour_q) + 1'b1);
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && colour_q == '1) |=> colour_q == '0);
  assert_reset_R1: assert property (@(posedge clk_i)
    !rst_ni |=> colour_q == '0);
endmodule

// File: rtl/colour_cycle_gen.sv
module colour_cycle_gen
  import colour_cycle_pkg::*;
#(
  parameter int unsigned STAGE0_BITS = 8,
  parameter int unsigned STAGE1_BITS = 8,
  parameter int unsigned STAGE2_BITS = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [COLOUR_W-1:0] colour_o
);
  localparam int unsigned TOTAL_BITS = STAGE0_BITS + STAGE1_BITS + STAGE2_BITS;
  localparam logic [TOTAL_BITS:0] LAST_GAP = {1'b0, {TOTAL_BITS{1'b1}}};

  logic step;

  prescale_chain #(
    .STAGE0_BITS (STAGE0_BITS),
    .STAGE1_BITS (STAGE1_BITS),
    .STAGE2_BITS (STAGE2_BITS)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (step)
  );

  colour_counter u_colour (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step),
    .colour_o (colour_o)
  );

  // pulse spacing monitor: clocks since reset or last step
  logic [TOTAL_BITS:0] gap_q;
  always_ff @(posedge clk_i) begin
    if (!rst_ni || step) gap_q <= '0;
    else                 gap_q <= gap_q + 1'b1;
  end

  assert_period_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> gap_q == LAST_GAP);
  assert_no_late_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= LAST_GAP);
endmodule

// File: tb/colour_cycle_gen_test.sv
module colour_cycle_gen_test;
  localparam int S0 = 1, S1 = 1, S2 = 1;
  localparam int PERIOD = 1 << (S0 + S1 + S2);
  localparam int WRAP = 256 * PERIOD;
  localparam int NVEC = 10;
  // {edges after reset release, expected colour}
  localparam int VEC [NVEC][2] = '{
    '{0, 0}, '{PERIOD-1, 0}, '{PERIOD, 1}, '{2*PERIOD-1, 1}, '{2*PERIOD, 2},
    '{WRAP-1, 255}, '{WRAP, 0}, '{WRAP+PERIOD, 1}, '{2*WRAP-1, 255}, '{2*WRAP, 0}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] colour_o;

  int n_checks = 0;
  int n_fail = 0;
  int edges = 0;
  bit done = 0;

  colour_cycle_gen #(.STAGE0_BITS(S0), .STAGE1_BITS(S1), .STAGE2_BITS(S2)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .colour_o (colour_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic check(string req, int exp);
    n_checks++;
    if (colour_o !== 8'(exp)) begin
      n_fail++;
      $display("FAIL %s edge %0d: colour_o=%0d expected %0d", req, edges, colour_o, exp);
    end
  endtask

  task automatic step_edges(int n);
    repeat (n) @(posedge clk_i);
    edges += n;
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step_edges(2);
    rst_ni = 1'b1;
    edges = 0;
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();
    check("R1", 0);

    // vector walk: R5 first step, R2 increments, R3 wraps, R4 period
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][0] > edges) step_edges(VEC[v][0] - edges);
      check(v < 5 ? "R5" : (v < 8 ? "R3" : "R4"), VEC[v][1]);
    end

    // full sweep over two more wraps: every code, both ends of each hold
    for (int k = 0; k < 2 * 256; k++) begin
      step_edges(PERIOD - 1);
      check("R2", (edges / PERIOD) % 256);
      step_edges(1);
      check("R4", (edges / PERIOD) % 256);
    end

    // R1: synchronous reset has no effect before the edge
    step_edges(5 * PERIOD);
    rst_ni = 1'b0;
    #3;
    check("R1", (edges / PERIOD) % 256);
    step_edges(1);
    check("R1", 0);
    rst_ni = 1'b1;
    edges = 0;
    // R6: prescaler stages were cleared too, so full period to first step
    step_edges(PERIOD - 1);
    check("R6", 0);
    step_edges(1);
    check("R6", 1);

    // R1: reset just before a step still clears to a full period
    step_edges(PERIOD - 1);
    do_reset();
    check("R1", 0);
    step_edges(PERIOD - 1);
    check("R5", 0);
    step_edges(1);
    check("R5", 1);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk_i);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule